// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits in the decode stage of a five-stage in-order pipeline. It owns the control half of the decode/execute pipeline register: the decoded control bundle and the destination register number of the instruction now in execute. Each cycle it compares the destination of a load in execute with the source registers of the instruction in decode. If the decode-stage instruction needs the loaded value before the forwarding paths can supply it, the block raises a stall.

During a stall, the program-counter write enable and the fetch/decode register write enable both drop, so the front end holds its instruction for one more cycle. At the same time, an all-zero control bundle and a zero destination enter the decode/execute register in place of the decoded values, which forms a bubble. The load and everything older keep moving. After that single bubble, the forwarding network resolves the dependence.

A two-state machine tracks the sequence. `ST_FLOW` is normal issue. The transition `insert_bubble` (hazard seen in `ST_FLOW`) leads to `ST_HOLD`, the cycle in which the bubble sits in execute. The unconditional transition `release` returns to `ST_FLOW`. A stall can only be raised from `ST_FLOW`.

Top module: `lu_stall_ctrl`

## Requirements
- R1: After reset, `ex_ctrl` and `ex_dst` are zero, `stall` is 0, and `pc_we` and `ifid_we` are 1.
- R2: `stall` is 1 in the same cycle when all three of these hold: `ex_ctrl[5]` (memory-read bit) is 1, `ex_dst` is nonzero, and `ex_dst` equals `dec_rs`.
- R3: `stall` is 1 when `ex_ctrl[5]` is 1, `ex_dst` is nonzero, `dec_rt_rd` is 1, `dec_ctrl[4]` (memory-write bit) is 0, and `ex_dst` equals `dec_rt`.
- R4: The Rt comparison has no effect when `dec_rt_rd` is 0. It also has no effect when `dec_ctrl[4]` is 1, because store data is forwarded at the memory stage.
- R5: A load whose destination is register 0 never causes a stall.
- R6: An instruction in execute with `ex_ctrl[5]` equal to 0 never causes a stall, even if its destination matches.
- R7: On the clock edge after a cycle with `stall` = 1, `ex_ctrl` and `ex_dst` become all zero.
- R8: On the clock edge after a cycle with `stall` = 0, `ex_ctrl` takes `dec_ctrl` and `ex_dst` takes `dec_dst`.
- R9: A stall lasts exactly one cycle. The cycle after a stall always has `stall` = 0.
- R10: Two loads, each followed directly by a dependent user, produce two separate one-cycle stalls with issue cycles between them.
- R11: `pc_we` and `ifid_we` are always equal, and both equal the inverse of `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_rs | input | REG_AW | First source register of the decode-stage instruction |
| dec_rt | input | REG_AW | Second source register of the decode-stage instruction |
| dec_rt_rd | input | 1 | Decode-stage instruction reads its second source |
| dec_dst | input | REG_AW | Destination register of the decode-stage instruction |
| dec_ctrl | input | 8 | Decoded control: [7] reg write, [6] mem-to-reg, [5] mem read, [4] mem write, [3] reg-dst select, [2] ALU source, [1:0] ALU op |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| stall | output | 1 | Load-use stall this cycle |
| ex_ctrl | output | 8 | Control bundle held in the decode/execute register |
| ex_dst | output | REG_AW | Destination register held in the decode/execute register |

## Verification
Two functions can act in the same cycle. The first is stall detection for the decode-stage instruction. The second is the choice of what enters execute, when the held instruction is itself a load or a store whose base register matches. The bench provokes this with a load followed by a load that uses the first result as its address. It also provokes it with a store that uses the loaded register as both base and data, and with a mixed run of back-to-back dependent loads.

A behavioural model of the pipeline front end, which replays a held instruction whenever the fetch/decode enable is low, predicts the stall, both enables and the decode/execute contents. These predictions are compared with the block on every clock. The comparison shows that each match produces one bubble, that the replayed instruction then issues with its own control intact, and that no extra stall follows.

// File: rtl/lu_pkg.sv
package lu_pkg;
    localparam int CTRL_W     = 8;
    localparam int CB_REGWR   = 7;
    localparam int CB_MEM2REG = 6;
    localparam int CB_MEMRD   = 5;
    localparam int CB_MEMWR   = 4;

    typedef enum logic [0:0] {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } lu_state_e;
endpackage

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect #(
    parameter int REG_AW = 5
) (
    input  logic              ex_mem_read,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic [REG_AW-1:0] dec_rs,
    input  logic [REG_AW-1:0] dec_rt,
    input  logic              dec_rt_rd,
    input  logic              dec_is_store,
    output logic              hazard
);
    logic dst_live;
    logic rs_hit;
    logic rt_hit;

    always_comb begin
        dst_live = ex_mem_read && (ex_dst != '0);
        rs_hit   = (ex_dst == dec_rs);
        // store data travels to memory stage, where it is forwarded
        rt_hit   = dec_rt_rd && !dec_is_store && (ex_dst == dec_rt);
        hazard   = dst_live && (rs_hit || rt_hit);
    end
endmodule

// File: rtl/lu_stall_fsm.sv
module lu_stall_fsm
    import lu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic stall,
    output logic front_we
);
    lu_state_e state_q;
    lu_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        stall    = 1'b0;
        front_we = 1'b1;
        unique case (state_q)
            ST_FLOW: begin
                if (hazard) begin
                    stall    = 1'b1;
                    front_we = 1'b0;
                    state_d  = ST_HOLD;
                end
            end
            ST_HOLD: begin
                state_d = ST_FLOW;
            end
            default: state_d = ST_FLOW;
        endcase
    end
endmodule

// File: rtl/lu_bubble_mux.sv
module lu_bubble_mux
    import lu_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              stall,
    input  logic [CTRL_W-1:0] dec_ctrl,
    input  logic [REG_AW-1:0] dec_dst,
    output logic [CTRL_W-1:0] nxt_ctrl,
    output logic [REG_AW-1:0] nxt_dst
);
    genvar gi;
    generate
        for (gi = 0; gi < CTRL_W; gi++) begin : g_ctrl
            assign nxt_ctrl[gi] = dec_ctrl[gi] & ~stall;
        end
    endgenerate

    assign nxt_dst = stall ? '0 : dec_dst;
endmodule

// File: rtl/lu_idex_ctrl.sv
module lu_idex_ctrl
    import lu_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] nxt_ctrl,
    input  logic [REG_AW-1:0] nxt_dst,
    output logic [CTRL_W-1:0] ex_ctrl,
    output logic [REG_AW-1:0] ex_dst
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_ctrl <= '0;
            ex_dst  <= '0;
        end else begin
            ex_ctrl <= nxt_ctrl;
            ex_dst  <= nxt_dst;
        end
    end
endmodule

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl
    import lu_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] dec_rs,
    input  logic [REG_AW-1:0] dec_rt,
    input  logic              dec_rt_rd,
    input  logic [REG_AW-1:0] dec_dst,
    input  logic [7:0]        dec_ctrl,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              stall,
    output logic [7:0]        ex_ctrl,
    output logic [REG_AW-1:0] ex_dst
);
    logic              hazard;
    logic              front_we;
    logic [CTRL_W-1:0] nxt_ctrl;
    logic [REG_AW-1:0] nxt_dst;

    lu_hazard_detect #(.REG_AW(REG_AW)) u_detect (
        .ex_mem_read  (ex_ctrl[CB_MEMRD]),
        .ex_dst       (ex_dst),
        .dec_rs       (dec_rs),
        .dec_rt       (dec_rt),
        .dec_rt_rd    (dec_rt_rd),
        .dec_is_store (dec_ctrl[CB_MEMWR]),
        .hazard       (hazard)
    );

    lu_stall_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hazard   (hazard),
        .stall    (stall),
        .front_we (front_we)
    );

    lu_bubble_mux #(.REG_AW(REG_AW)) u_mux (
        .stall    (stall),
        .dec_ctrl (dec_ctrl),
        .dec_dst  (dec_dst),
        .nxt_ctrl (nxt_ctrl),
        .nxt_dst  (nxt_dst)
    );

    lu_idex_ctrl #(.REG_AW(REG_AW)) u_idex (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_ctrl (nxt_ctrl),
        .nxt_dst  (nxt_dst),
        .ex_ctrl  (ex_ctrl),
        .ex_dst   (ex_dst)
    );

    assign pc_we   = front_we;
    assign ifid_we = front_we;
endmodule

// File: rtl/lu_stall_ctrl_chk.sv
module lu_stall_ctrl_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              pc_we,
    input logic              ifid_we,
    input logic [7:0]        dec_ctrl,
    input logic [REG_AW-1:0] dec_dst,
    input logic [7:0]        ex_ctrl,
    input logic [REG_AW-1:0] ex_dst
);
    // R7
    bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (ex_ctrl == '0) && (ex_dst == '0));

    // R8
    issue_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (ex_ctrl == $past(dec_ctrl)) && (ex_dst == $past(dec_dst)));

    // R9
    single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R11
    front_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we == ifid_we) && (pc_we == !stall));

    // R2
    stall_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ex_ctrl[5] && (ex_dst != '0));
endmodule

bind lu_stall_ctrl lu_stall_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .pc_we    (pc_we),
    .ifid_we  (ifid_we),
    .dec_ctrl (dec_ctrl),
    .dec_dst  (dec_dst),
    .ex_ctrl  (ex_ctrl),
    .ex_dst   (ex_dst)
);

// File: tb/lu_stall_ctrl_test.sv
`timescale 1ns/1ps
module lu_stall_ctrl_test;
    localparam int AW = 5;
    localparam logic [7:0] C_LW  = 8'b1110_0100;
    localparam logic [7:0] C_SW  = 8'b0001_0100;
    localparam logic [7:0] C_ALU = 8'b1000_1010;
    localparam logic [7:0] C_NOP = 8'b0000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] dec_rs = '0, dec_rt = '0, dec_dst = '0;
    logic          dec_rt_rd = 1'b0;
    logic [7:0]    dec_ctrl = '0;
    logic          pc_we, ifid_we, stall;
    logic [7:0]    ex_ctrl;
    logic [AW-1:0] ex_dst;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // behavioural reference state
    logic [7:0]    m_ctrl;
    logic [AW-1:0] m_dst;
    bit            m_prev_stall;

    // program store
    logic [AW-1:0] p_rs[$], p_rt[$], p_dst[$];
    logic          p_rtrd[$];
    logic [7:0]    p_ctrl[$];
    string         p_tag[$];

    always #4 clk = ~clk;

    lu_stall_ctrl #(.REG_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .dec_rs(dec_rs), .dec_rt(dec_rt),
        .dec_rt_rd(dec_rt_rd), .dec_dst(dec_dst), .dec_ctrl(dec_ctrl),
        .pc_we(pc_we), .ifid_we(ifid_we), .stall(stall),
        .ex_ctrl(ex_ctrl), .ex_dst(ex_dst)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_stall();
        bit rt_counts;
        if (m_prev_stall) return 1'b0;
        if (!m_ctrl[5] || m_dst == 0) return 1'b0;
        rt_counts = dec_rt_rd && !dec_ctrl[4];
        return (m_dst == dec_rs) || (rt_counts && m_dst == dec_rt);
    endfunction

    task automatic add_instr(input logic [7:0] c, input int dst, input int rs,
                             input int rt, input bit rtrd, input string tag);
        p_ctrl.push_back(c); p_dst.push_back(dst[AW-1:0]);
        p_rs.push_back(rs[AW-1:0]); p_rt.push_back(rt[AW-1:0]);
        p_rtrd.push_back(rtrd); p_tag.push_back(tag);
    endtask

    // one cycle: inputs already driven; compare at negedge, update at posedge
    task automatic cycle_once(input string tag, output bit exp_stall);
        @(negedge clk);
        exp_stall = model_stall();
        check(tag, "stall", int'(stall), int'(exp_stall));
        check("R11", "pc_we", int'(pc_we), int'(!exp_stall));
        check("R11", "ifid_we", int'(ifid_we), int'(!exp_stall));
        @(posedge clk);
        if (exp_stall) begin
            m_ctrl = '0; m_dst = '0;
        end else begin
            m_ctrl = dec_ctrl; m_dst = dec_dst;
        end
        m_prev_stall = exp_stall;
        #1;
        check(exp_stall ? "R7" : "R8", "ex_ctrl", int'(ex_ctrl), int'(m_ctrl));
        check(exp_stall ? "R7" : "R8", "ex_dst", int'(ex_dst), int'(m_dst));
    endtask

    task automatic run_prog(output int n_stalls);
        int idx = 0;
        bit es;
        n_stalls = 0;
        while (idx < p_ctrl.size()) begin
            dec_ctrl = p_ctrl[idx]; dec_dst = p_dst[idx];
            dec_rs = p_rs[idx]; dec_rt = p_rt[idx]; dec_rt_rd = p_rtrd[idx];
            cycle_once(p_tag[idx], es);
            if (es) n_stalls++;
            else idx++;
        end
        dec_ctrl = C_NOP; dec_dst = '0; dec_rs = '0; dec_rt = '0; dec_rt_rd = 0;
        cycle_once("R8", es);
        p_ctrl.delete(); p_dst.delete(); p_rs.delete();
        p_rt.delete(); p_rtrd.delete(); p_tag.delete();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int ns;
        m_ctrl = '0; m_dst = '0; m_prev_stall = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ex_ctrl", int'(ex_ctrl), 0);
        check("R1", "ex_dst", int'(ex_dst), 0);
        check("R1", "stall", int'(stall), 0);
        check("R1", "pc_we", int'(pc_we), 1);
        check("R1", "ifid_we", int'(ifid_we), 1);
        @(posedge clk); #1;

        // R2 / R10: two loads each with a dependent user
        add_instr(C_LW,  1, 2, 0, 0, "R2");
        add_instr(C_ALU, 2, 1, 5, 1, "R2");
        add_instr(C_LW,  3, 4, 0, 0, "R10");
        add_instr(C_ALU, 4, 7, 3, 1, "R3");
        run_prog(ns);
        check("R10", "stall count", ns, 2);

        // R4 store data and unread Rt; R5 zero dest; R6 non-load writer
        add_instr(C_LW,  6, 2, 0, 0, "R4");
        add_instr(C_SW,  0, 8, 6, 1, "R4");
        add_instr(C_LW,  6, 2, 0, 0, "R4");
        add_instr(C_ALU, 9, 9, 6, 0, "R4");
        add_instr(C_LW,  0, 2, 0, 0, "R5");
        add_instr(C_ALU, 1, 0, 0, 1, "R5");
        add_instr(C_ALU, 10, 1, 2, 1, "R6");
        add_instr(C_ALU, 11, 10, 10, 1, "R6");
        run_prog(ns);
        check("R4", "stall count", ns, 0);

        // stall coinciding with held load / store base
        add_instr(C_LW,  11, 2, 0, 0, "R2");
        add_instr(C_SW,  0, 11, 11, 1, "R2");
        add_instr(C_LW,  12, 3, 0, 0, "R2");
        add_instr(C_LW,  13, 12, 0, 0, "R9");
        add_instr(C_ALU, 14, 5, 13, 1, "R3");
        add_instr(C_ALU, 15, 13, 14, 1, "R9");
        run_prog(ns);
        check("R9", "stall count", ns, 3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule